// File: doc/BRIEF.md
# Multi-Size Set-Associative Translation Cache

This block caches the results of page table walks so that repeated address translations do not have to walk memory again. It holds entries for three page sizes: 4 KB small pages, 64 KB large pages and 1 MB sections. The storage is 64 sets of 8 ways. The set is always chosen by virtual address bits [17:12], whatever the page size. Each entry stores its own size code, and the tag compare ignores the virtual page bits that lie inside that page's offset. A large page therefore occupies only the set picked by the address that caused its fill. The same page can sit separately in up to 16 sets for a 64 KB page, or in any of the 64 sets for a 1 MB section.

A requester presents a lookup and receives hit, physical address and size one cycle later. On a miss, an external walker writes the result back through the fill port. The victim way is an invalid way if the set has one, and otherwise the least recently used way. Software-side control can clear the whole cache, or clear the entries that cover one 4 KB-aligned address in its set. Removing a large page completely takes one such entry clear for every 4 KB step of the page, up to the 64-set limit. If two ways match one lookup, a multi-hit is reported instead of a translation.

Top module: `mst_tlb`

## Requirements
- R1: After reset every lookup misses and no response is signalled until a lookup is accepted.
- R2: An accepted lookup produces exactly one response, in the cycle after it is presented (rsp_valid_o high for one cycle). No response appears without an accepted lookup.
- R3: Size codes are 2'b00 = 4 KB, 2'b01 = 64 KB, 2'b10 = 1 MB. On a hit, the physical address takes the stored frame bits above the page offset and the lookup address bits inside it, and the stored size code is returned.
- R4: The set index is virtual address bits [17:12] for all sizes. A lookup to another 4 KB step of a large page misses unless that step's set was also filled.
- R5: A fill writes the lowest-numbered invalid way of its set. If every way is valid, it replaces the least recently used way. Fills and single hits both count as uses.
- R6: When more than one valid way matches a lookup, the response has rsp_multihit_o = 1, rsp_hit_o = 0, a zero address, and no recency update.
- R7: A full invalidate clears every entry, so each lookup that follows misses until a new fill.
- R8: An entry invalidate takes a 4 KB page number. In the set given by its low 6 bits, it clears every valid entry whose tag matches that page number under the entry's own size mask. Entries in other sets are left alone.
- R9: Only one operation is accepted per cycle, in the priority order full invalidate, entry invalidate, fill, lookup. A lower-priority request in the same cycle is dropped with no effect, and a dropped lookup gets no response.
- R10: A miss response has rsp_hit_o = 0, rsp_pa_o = 0 and rsp_size_o = 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_valid_i | input | 1 | Translation request |
| lookup_va_i | input | VA_W | Virtual address to translate |
| rsp_valid_o | output | 1 | Response for the lookup of the previous cycle |
| rsp_hit_o | output | 1 | Exactly one way matched |
| rsp_multihit_o | output | 1 | More than one way matched |
| rsp_pa_o | output | PA_W | Translated physical address |
| rsp_size_o | output | 2 | Size code of the hitting entry |
| fill_valid_i | input | 1 | Write a walk result |
| fill_vpn_i | input | VA_W-12 | Virtual 4 KB page number of the fill |
| fill_ppn_i | input | PA_W-12 | Physical 4 KB frame number of the fill |
| fill_size_i | input | 2 | Size code of the fill |
| inv_all_i | input | 1 | Clear every entry |
| inv_entry_i | input | 1 | Clear the entries covering one page number |
| inv_vpn_i | input | VA_W-12 | 4 KB page number for the entry clear |

## Verification
A stale valid bit or wrong tag shows up at the response of the very next lookup to that set, as a hit where a miss was due, as a wrong address, or as a false multi-hit. A corrupted recency order stays hidden until a set is full and a fill evicts the wrong way. The bench therefore fills a set past its capacity and probes the survivors one cycle later. A mask error in entry invalidation shows up as a large page that survives a clear issued at one of its inner 4 KB addresses. The reference model is checked against every output in every cycle, so each of these faults is caught at the first response that depends on it.

// File: rtl/mst_tlb_pkg.sv
package mst_tlb_pkg;
  typedef enum logic [1:0] {
    PG_4K   = 2'b00,
    PG_64K  = 2'b01,
    PG_1M   = 2'b10,
    PG_RSVD = 2'b11
  } pg_size_e;
endpackage

// File: rtl/mst_tlb_cmp.sv
module mst_tlb_cmp
  import mst_tlb_pkg::*;
#(
  parameter int VPN_W    = 20,
  parameter int MID_DROP = 4,
  parameter int BIG_DROP = 8
) (
  input  logic             vld_i,
  input  logic [1:0]       sz_i,
  input  logic [VPN_W-1:0] tag_i,
  input  logic [VPN_W-1:0] key_i,
  output logic             match_o,
  output logic [VPN_W-1:0] low_mask_o
);
  localparam logic [VPN_W-1:0] MID_M = {{(VPN_W-MID_DROP){1'b0}}, {MID_DROP{1'b1}}};
  localparam logic [VPN_W-1:0] BIG_M = {{(VPN_W-BIG_DROP){1'b0}}, {BIG_DROP{1'b1}}};

  always_comb begin
    unique case (pg_size_e'(sz_i))
      PG_64K:  low_mask_o = MID_M;
      PG_1M:   low_mask_o = BIG_M;
      default: low_mask_o = '0;
    endcase
    match_o = vld_i && (((tag_i ^ key_i) & ~low_mask_o) == '0);
  end
endmodule

// File: rtl/mst_tlb_lru.sv
module mst_tlb_lru #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_en_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] row_nxt [WAYS];

  // next ages of the touched set: touched way becomes youngest
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      row_nxt[w] = age_q[touch_set_i][w];
      if (WAY_W'(w) == touch_way_i)
        row_nxt[w] = '0;
      else if (age_q[touch_set_i][w] < age_q[touch_set_i][touch_way_i])
        row_nxt[w] = age_q[touch_set_i][w] + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en_i) begin
      for (int w = 0; w < WAYS; w++)
        age_q[touch_set_i][w] <= row_nxt[w];
    end
  end

  always_comb begin
    victim_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[touch_set_i][w] == WAY_W'(WAYS-1))
        victim_o = WAY_W'(w);
  end
endmodule

// File: rtl/mst_tlb_pick.sv
module mst_tlb_pick #(
  parameter int WAYS  = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int CNT_W = $clog2(WAYS+1)
) (
  input  logic [WAYS-1:0]  vld_i,
  input  logic [WAYS-1:0]  match_i,
  input  logic [WAY_W-1:0] lru_way_i,
  output logic [WAY_W-1:0] fill_way_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [CNT_W-1:0] hit_cnt_o
);
  logic found;

  always_comb begin
    found      = 1'b0;
    fill_way_o = lru_way_i;
    for (int w = 0; w < WAYS; w++) begin
      if (!vld_i[w] && !found) begin
        fill_way_o = WAY_W'(w);
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    hit_way_o = '0;
    hit_cnt_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_i[w]) begin
        hit_way_o = WAY_W'(w);
        hit_cnt_o = hit_cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mst_tlb.sv
module mst_tlb #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PG_SHIFT  = 12,
  parameter int MID_SHIFT = 16,
  parameter int BIG_SHIFT = 20,
  parameter int SET_BITS  = 6,
  parameter int WAYS      = 8,
  localparam int VPN_W = VA_W - PG_SHIFT,
  localparam int PPN_W = PA_W - PG_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lookup_valid_i,
  input  logic [VA_W-1:0]  lookup_va_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic             rsp_multihit_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic [1:0]       rsp_size_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic [1:0]       fill_size_i,
  input  logic             inv_all_i,
  input  logic             inv_entry_i,
  input  logic [VPN_W-1:0] inv_vpn_i
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int WAY_W = $clog2(WAYS);
  localparam int CNT_W = $clog2(WAYS+1);

  // storage
  logic             vld_q [SETS][WAYS];
  logic [VPN_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];
  logic [1:0]       sz_q  [SETS][WAYS];

  // operation decode
  logic                op_inv_all, op_inv_ent, op_fill, op_look;
  logic [VPN_W-1:0]    key_vpn;
  logic [SET_BITS-1:0] set_idx;

  always_comb begin
    op_inv_all = inv_all_i;
    op_inv_ent = inv_entry_i & ~inv_all_i;
    op_fill    = fill_valid_i & ~inv_all_i & ~inv_entry_i;
    op_look    = lookup_valid_i & ~inv_all_i & ~inv_entry_i & ~fill_valid_i;
    key_vpn    = op_inv_ent ? inv_vpn_i : lookup_va_i[VA_W-1:PG_SHIFT];
    set_idx    = op_fill ? fill_vpn_i[SET_BITS-1:0] : key_vpn[SET_BITS-1:0];
  end

  // per-way compare on the indexed set
  logic [WAYS-1:0]  row_vld, row_match;
  logic [VPN_W-1:0] row_low [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign row_vld[g] = vld_q[set_idx][g];
    mst_tlb_cmp #(
      .VPN_W   (VPN_W),
      .MID_DROP(MID_SHIFT - PG_SHIFT),
      .BIG_DROP(BIG_SHIFT - PG_SHIFT)
    ) cmp_i (
      .vld_i     (vld_q[set_idx][g]),
      .sz_i      (sz_q[set_idx][g]),
      .tag_i     (tag_q[set_idx][g]),
      .key_i     (key_vpn),
      .match_o   (row_match[g]),
      .low_mask_o(row_low[g])
    );
  end

  // way selection and recency
  logic [WAY_W-1:0] lru_way, fill_way, hit_way;
  logic [CNT_W-1:0] hit_cnt;
  logic             single_hit, touch_en;
  logic [WAY_W-1:0] touch_way;

  mst_tlb_pick #(.WAYS(WAYS)) pick_i (
    .vld_i     (row_vld),
    .match_i   (row_match),
    .lru_way_i (lru_way),
    .fill_way_o(fill_way),
    .hit_way_o (hit_way),
    .hit_cnt_o (hit_cnt)
  );

  always_comb begin
    single_hit = op_look && (hit_cnt == CNT_W'(1));
    touch_en   = op_fill | single_hit;
    touch_way  = op_fill ? fill_way : hit_way;
  end

  mst_tlb_lru #(.SETS(SETS), .WAYS(WAYS)) lru_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_en_i (touch_en),
    .touch_set_i(set_idx),
    .touch_way_i(touch_way),
    .victim_o   (lru_way)
  );

  // valid bits: next state
  logic [WAYS-1:0] row_vld_nxt;
  logic            row_we;

  always_comb begin
    row_vld_nxt = row_vld;
    if (op_inv_ent) row_vld_nxt = row_vld & ~row_match;
    if (op_fill)    row_vld_nxt[fill_way] = 1'b1;
    row_we = op_inv_ent | op_fill;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          vld_q[s][w] <= 1'b0;
    end else if (op_inv_all) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          vld_q[s][w] <= 1'b0;
    end else if (row_we) begin
      for (int w = 0; w < WAYS; w++)
        vld_q[set_idx][w] <= row_vld_nxt[w];
    end
  end

  // entry payload, written only on fill
  always_ff @(posedge clk_i) begin
    if (op_fill) begin
      tag_q[set_idx][fill_way] <= fill_vpn_i;
      ppn_q[set_idx][fill_way] <= fill_ppn_i;
      sz_q[set_idx][fill_way]  <= fill_size_i;
    end
  end

  // response: next state
  logic             rsp_valid_d, rsp_hit_d, rsp_multi_d;
  logic [PA_W-1:0]  rsp_pa_d;
  logic [1:0]       rsp_size_d;
  logic [PPN_W-1:0] ppn_low, ppn_out;

  always_comb begin
    ppn_low     = PPN_W'(row_low[hit_way]);
    ppn_out     = (ppn_q[set_idx][hit_way] & ~ppn_low) | (PPN_W'(key_vpn) & ppn_low);
    rsp_valid_d = op_look;
    rsp_hit_d   = single_hit;
    rsp_multi_d = op_look && (hit_cnt > CNT_W'(1));
    rsp_pa_d    = single_hit ? {ppn_out, lookup_va_i[PG_SHIFT-1:0]} : '0;
    rsp_size_d  = single_hit ? sz_q[set_idx][hit_way] : 2'b00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      rsp_hit_o      <= 1'b0;
      rsp_multihit_o <= 1'b0;
      rsp_pa_o       <= '0;
      rsp_size_o     <= 2'b00;
    end else begin
      rsp_valid_o    <= rsp_valid_d;
      rsp_hit_o      <= rsp_hit_d;
      rsp_multihit_o <= rsp_multi_d;
      rsp_pa_o       <= rsp_pa_d;
      rsp_size_o     <= rsp_size_d;
    end
  end
endmodule

// File: rtl/mst_tlb_chk.sv
module mst_tlb_chk #(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PG_SHIFT = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lookup_valid_i,
  input logic [VA_W-1:0] lookup_va_i,
  input logic            fill_valid_i,
  input logic            inv_all_i,
  input logic            inv_entry_i,
  input logic            rsp_valid_o,
  input logic            rsp_hit_o,
  input logic            rsp_multihit_o,
  input logic [PA_W-1:0] rsp_pa_o,
  input logic [1:0]      rsp_size_o
);
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && !fill_valid_i && !inv_all_i && !inv_entry_i) |=> rsp_valid_o); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> !rsp_valid_o); // R2
  AST_DROPPED_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i || inv_all_i || inv_entry_i) |=> !rsp_valid_o); // R9
  AST_PA_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_pa_o[PG_SHIFT-1:0] == $past(lookup_va_i[PG_SHIFT-1:0])); // R3
  AST_MULTI_NOT_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_multihit_o |-> (!rsp_hit_o && rsp_pa_o == '0)); // R6
  AST_FLUSH_THEN_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i ##1 (lookup_valid_i && !fill_valid_i && !inv_entry_i && !inv_all_i)
    |=> (!rsp_hit_o && !rsp_multihit_o)); // R7
  AST_MISS_ZEROED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_pa_o == '0 && rsp_size_o == 2'b00)); // R10
  AST_RESULT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_hit_o || rsp_multihit_o) |-> rsp_valid_o); // R2
endmodule

bind mst_tlb mst_tlb_chk #(
  .VA_W    (VA_W),
  .PA_W    (PA_W),
  .PG_SHIFT(PG_SHIFT)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lookup_valid_i(lookup_valid_i),
  .lookup_va_i   (lookup_va_i),
  .fill_valid_i  (fill_valid_i),
  .inv_all_i     (inv_all_i),
  .inv_entry_i   (inv_entry_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_hit_o     (rsp_hit_o),
  .rsp_multihit_o(rsp_multihit_o),
  .rsp_pa_o      (rsp_pa_o),
  .rsp_size_o    (rsp_size_o)
);

// File: tb/mst_tlb_tb_top.sv
module mst_tlb_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        lookup_valid_i;
  logic [31:0] lookup_va_i;
  logic        rsp_valid_o, rsp_hit_o, rsp_multihit_o;
  logic [31:0] rsp_pa_o;
  logic [1:0]  rsp_size_o;
  logic        fill_valid_i;
  logic [19:0] fill_vpn_i, fill_ppn_i;
  logic [1:0]  fill_size_i;
  logic        inv_all_i, inv_entry_i;
  logic [19:0] inv_vpn_i;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mst_tlb dut_i (.*);

  typedef struct {
    logic [19:0] vpn;
    logic [19:0] ppn;
    logic [1:0]  sz;
  } ent_t;

  ent_t mdl [64][$];   // per set, front = most recently used
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;
  logic        e_v, e_hit, e_mh;
  logic [31:0] e_pa;
  logic [1:0]  e_sz;

  function automatic logic [19:0] lowm(logic [1:0] sz);
    if (sz == 2'b01) return 20'h0000F;
    if (sz == 2'b10) return 20'h000FF;
    return 20'h0;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference, evaluated on the inputs of the coming edge
  task automatic model_step();
    int s;
    e_v = 0; e_hit = 0; e_mh = 0; e_pa = 0; e_sz = 0;
    if (inv_all_i) begin
      for (int k = 0; k < 64; k++) mdl[k].delete();
    end else if (inv_entry_i) begin
      s = int'(inv_vpn_i[5:0]);
      for (int i = mdl[s].size()-1; i >= 0; i--)
        if (((mdl[s][i].vpn ^ inv_vpn_i) & ~lowm(mdl[s][i].sz)) == 20'h0)
          mdl[s].delete(i);
    end else if (fill_valid_i) begin
      ent_t e;
      s = int'(fill_vpn_i[5:0]);
      e.vpn = fill_vpn_i; e.ppn = fill_ppn_i; e.sz = fill_size_i;
      if (mdl[s].size() >= 8) void'(mdl[s].pop_back());
      mdl[s].push_front(e);
    end else if (lookup_valid_i) begin
      int cnt = 0, idx = 0;
      logic [19:0] key = lookup_va_i[31:12];
      s = int'(key[5:0]);
      e_v = 1;
      for (int i = 0; i < mdl[s].size(); i++)
        if (((mdl[s][i].vpn ^ key) & ~lowm(mdl[s][i].sz)) == 20'h0) begin
          cnt++; idx = i;
        end
      if (cnt == 1) begin
        ent_t e = mdl[s][idx];
        logic [19:0] m = lowm(e.sz);
        e_hit = 1;
        e_sz  = e.sz;
        e_pa  = {(e.ppn & ~m) | (key & m), lookup_va_i[11:0]};
        mdl[s].delete(idx);
        mdl[s].push_front(e);
      end else if (cnt > 1) begin
        e_mh = 1;
      end
    end
  endtask

  task automatic idle_inputs();
    lookup_valid_i = 0; lookup_va_i = 0;
    fill_valid_i = 0; fill_vpn_i = 0; fill_ppn_i = 0; fill_size_i = 0;
    inv_all_i = 0; inv_entry_i = 0; inv_vpn_i = 0;
  endtask

  task automatic cyc(string tag);
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag, "rsp_valid", {31'b0, rsp_valid_o}, {31'b0, e_v});
    check(tag, "rsp_hit", {31'b0, rsp_hit_o}, {31'b0, e_hit});
    check(tag, "rsp_multihit", {31'b0, rsp_multihit_o}, {31'b0, e_mh});
    check(tag, "rsp_pa", rsp_pa_o, e_pa);
    check(tag, "rsp_size", {30'b0, rsp_size_o}, {30'b0, e_sz});
    idle_inputs();
  endtask

  task automatic look(logic [31:0] va, string tag);
    lookup_valid_i = 1; lookup_va_i = va; cyc(tag);
  endtask

  task automatic fill(logic [31:0] va, logic [31:0] pa, logic [1:0] sz, string tag);
    fill_valid_i = 1; fill_vpn_i = va[31:12]; fill_ppn_i = pa[31:12]; fill_size_i = sz;
    cyc(tag);
  endtask

  task automatic inv_one(logic [31:0] va, string tag);
    inv_entry_i = 1; inv_vpn_i = va[31:12]; cyc(tag);
  endtask

  task automatic inv_every(string tag);
    inv_all_i = 1; cyc(tag);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    idle_inputs();
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    check("R1", "rsp_valid in reset", {31'b0, rsp_valid_o}, 32'h0);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 / R10: empty cache misses
    look(32'h1234_5678, "R1");
    look(32'h0000_0000, "R10");

    // R2 / R3: 4 KB translation
    fill(32'h1234_5000, 32'hABCD_E000, 2'b00, "R3");
    look(32'h1234_5678, "R3");
    look(32'h1234_6678, "R2");

    // R3 / R4: 64 KB page lives only in its fill set
    fill(32'h0042_3000, 32'h7770_0000, 2'b01, "R4");
    look(32'h0042_3ABC, "R3");
    look(32'h0042_4ABC, "R4");

    // R3: 1 MB section
    fill(32'h0550_7000, 32'h9000_0000, 2'b10, "R3");
    look(32'h0550_7123, "R3");

    // R8: entry clear at an inner address of the section, same set
    inv_one(32'h0558_7000, "R8");
    look(32'h0550_7123, "R8");

    // R8: 64 KB page filled in all 16 sets, then cleared step by step
    for (int k = 0; k < 16; k++)
      fill(32'h0042_0000 + k*32'h1000, 32'h7770_0000, 2'b01, "R8");
    inv_one(32'h0042_3000, "R8");
    look(32'h0042_3ABC, "R8");
    look(32'h0042_5ABC, "R8");
    for (int k = 0; k < 16; k++) inv_one(32'h0042_0000 + k*32'h1000, "R8");
    for (int k = 0; k < 16; k++) look(32'h0042_0010 + k*32'h1000, "R8");

    // R7: full clear
    look(32'h1234_5678, "R7");
    inv_every("R7");
    look(32'h1234_5678, "R7");

    // R5: fill set 5 past capacity after a recency refresh
    for (int k = 0; k < 8; k++) fill((k << 18) | 32'h5000, 32'h1000_0000 + k*32'h1000, 2'b00, "R5");
    look(32'h0000_5004, "R5");
    fill((8 << 18) | 32'h5000, 32'h2000_0000, 2'b00, "R5");
    look((1 << 18) | 32'h5008, "R5");
    look(32'h0000_500C, "R5");
    look((2 << 18) | 32'h5010, "R5");
    look((8 << 18) | 32'h5014, "R5");

    // R6: duplicate page -> multi-hit
    inv_every("R7");
    fill(32'h0A00_0000, 32'h3000_0000, 2'b00, "R6");
    fill(32'h0A00_0000, 32'h4000_0000, 2'b00, "R6");
    look(32'h0A00_0ABC, "R6");
    inv_one(32'h0A00_0000, "R8");
    look(32'h0A00_0ABC, "R8");

    // R9: priorities
    fill(32'h0B00_1000, 32'h5000_1000, 2'b00, "R9");
    fill_valid_i = 1; fill_vpn_i = 20'h0B002; fill_ppn_i = 20'h50002; fill_size_i = 2'b00;
    lookup_valid_i = 1; lookup_va_i = 32'h0B00_1111;
    cyc("R9");
    look(32'h0B00_2222, "R9");
    inv_entry_i = 1; inv_vpn_i = 20'h0B002;
    fill_valid_i = 1; fill_vpn_i = 20'h0B003; fill_ppn_i = 20'h50003; fill_size_i = 2'b00;
    cyc("R9");
    look(32'h0B00_3333, "R9");
    look(32'h0B00_2222, "R9");
    inv_all_i = 1; inv_entry_i = 1; inv_vpn_i = 20'h0B001;
    fill_valid_i = 1; fill_vpn_i = 20'h0B004; fill_ppn_i = 20'h50004;
    cyc("R9");
    look(32'h0B00_1444, "R9");
    look(32'h0B00_4444, "R9");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule